// File: doc/BRIEF.md
# DMA Channel Request Latch Controller

This block is the request-capture front end of a single DMA channel. One of several peripheral request lines, chosen by a source-select field, is synchronised and edge-detected. A host write can also raise a software trigger. Either one sets a one-bit request flag. In the cycle after the flag is set, the flag is consumed in one of two ways:

- If the channel is enabled, not locked out and holds a non-zero transfer count, it becomes a one-cycle start pulse and the count goes down by one.
- Otherwise the request is silently dropped.

The host programs the block through three write strobes that share one data bus: the cause register, the mode register and the transfer-count load. All three can be read back. Any write that changes the selected source, or switches between software and hardware triggering, starts a settle lockout. During the lockout the channel behaves as disabled, whatever the mode register says. Address generation and data movement sit downstream of `start_o`.

Top module: `dma_req_latch`

## Requirements
- R1: A request latched while the mode field reads 00, or while the count is 0, produces no start pulse. The flag reads 0 one cycle later, and later enabling the channel does not revive the request.
- R2: A cause write with bit 7 and bit 5 both 1 sets the flag; on an enabled, unlocked channel with a non-zero count, `start_o` is high in the cycle after the write. A write with bit 5 = 1 and bit 7 = 0 triggers nothing.
- R3: With bit 5 stored as 0, a rising edge on the request line indexed by cause bits 3:0 raises `start_o` exactly once, however long the line stays high. Edges on other lines have no effect.
- R4: While bit 5 is stored as 1, peripheral request lines have no effect.
- R5: A cause write that changes bits 3:0 or bit 5 blocks every transfer for 26 cycles. Requests in that window are dropped, and requests after it are granted.
- R6: Each start pulse decrements the count by one. At count 0 no start occurs and the count stays 0.
- R7: Reads return the mode in bits 1:0 and zeros above. The cause reads back with the flag in bit 7, the software select in bit 5 and the source in bits 3:0; bits 6 and 4 read as 0.
- R8: A hardware request that lands in the same cycle as a cause write with bit 7 = 0 is not lost: it still produces a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Host write data for the cause and mode registers |
| wr_cause_i | input | 1 | Write strobe for the cause register |
| wr_mode_i | input | 1 | Write strobe for the mode register |
| cnt_wdata_i | input | CNT_W | Transfer count load value |
| wr_cnt_i | input | 1 | Write strobe for the transfer count |
| periph_req_i | input | N_SRC | Peripheral request lines, asynchronous |
| cause_o | output | 8 | Cause register read-back |
| mode_o | output | 8 | Mode register read-back |
| cnt_o | output | CNT_W | Remaining transfer count |
| start_o | output | 1 | One-cycle transfer start pulse |

## Verification
The channel is driven with the following patterns:

- **Long pulse on the selected line:** separates edge capture from level capture.
- **Pulse on an unselected line:** exposes decoding of the wrong source.
- **Software-trigger writes with and without the flag bit:** distinguishes the paired-bit rule from a single-bit trigger.
- **Requests while disabled, at zero count, and inside the settle window:** show that a dropped request does not linger and fire later.
- **Host flag-clear write timed onto the cycle the edge is captured:** separates set-priority from clear-priority.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int CAUSE_W = 8;
  localparam int REQ_BIT = 7;
  localparam int SW_BIT  = 5;
  localparam int MODE_W  = 2;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int N_SRC  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] rise_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], req_i[g]};
    end
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/dma_req_lockout.sv
module dma_req_lockout #(
  parameter int LOCK_CYC = 26
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic locked_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= LW'(LOCK_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign locked_o = (cnt_q != '0);
endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch
  import dma_req_pkg::*;
#(
  parameter int N_SRC    = 16,
  parameter int CNT_W    = 16,
  parameter int LOCK_CYC = 26,
  parameter int STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       wdata_i,
  input  logic             wr_cause_i,
  input  logic             wr_mode_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             wr_cnt_i,
  input  logic [N_SRC-1:0] periph_req_i,
  output logic [7:0]       cause_o,
  output logic [7:0]       mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic              req_q, sw_q;
  logic [SEL_W-1:0]  sel_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_SRC-1:0]  rise;
  logic              locked, hw_set, sw_set, sel_chg, chan_ok;
  logic              unused_w;

  assign unused_w = ^{wdata_i[6], wdata_i[4]};

  dma_req_sync #(.N_SRC(N_SRC), .STAGES(STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (periph_req_i),
    .rise_o(rise)
  );

  // cause-field change restarts the settle window
  assign sel_chg = wr_cause_i &&
                   ((wdata_i[SW_BIT] != sw_q) || (wdata_i[SEL_W-1:0] != sel_q));

  dma_req_lockout #(.LOCK_CYC(LOCK_CYC)) i_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sel_chg),
    .locked_o(locked)
  );

  assign hw_set  = !sw_q && rise[sel_q];
  assign sw_set  = wr_cause_i && wdata_i[REQ_BIT] && wdata_i[SW_BIT];
  assign chan_ok = (mode_q != '0) && !locked && (cnt_q != '0);
  assign start_o = req_q && chan_ok;

  // flag lives one cycle: granted or dropped; a new set always wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= hw_set | sw_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_cause_i) begin
      sw_q  <= wdata_i[SW_BIT];
      sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (wr_mode_i) mode_q <= wdata_i[MODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= cnt_wdata_i;
    else if (start_o)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    cause_o              = '0;
    cause_o[REQ_BIT]     = req_q;
    cause_o[SW_BIT]      = sw_q;
    cause_o[SEL_W-1:0]   = sel_q;
    mode_o               = '0;
    mode_o[MODE_W-1:0]   = mode_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_req_latch_chk.sv
module dma_req_latch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       wdata_i,
  input logic             wr_cause_i,
  input logic             wr_cnt_i,
  input logic [7:0]       cause_o,
  input logic [7:0]       mode_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             start_o,
  input logic             locked,
  input logic             hw_set
);
  p_no_start_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1:0] == 2'b00) |-> !start_o);

  p_flag_consumed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[7] && !hw_set && !(wr_cause_i && wdata_i[7] && wdata_i[5])) |=> !cause_o[7]);

  p_no_start_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !locked);

  p_lock_on_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cause_i && ((wdata_i[5] != cause_o[5]) || (wdata_i[3:0] != cause_o[3:0]))) |=> locked);

  p_dec_on_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !wr_cnt_i) |=> (cnt_o == $past(cnt_o) - 1'b1));

  p_zero_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> !start_o);

  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && !wr_cnt_i) |=> $stable(cnt_o));

  p_mode_pad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[7:2] == '0) && (cause_o[6] == 1'b0) && (cause_o[4] == 1'b0));
endmodule

bind dma_req_latch dma_req_latch_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdata_i   (wdata_i),
  .wr_cause_i(wr_cause_i),
  .wr_cnt_i  (wr_cnt_i),
  .cause_o   (cause_o),
  .mode_o    (mode_o),
  .cnt_o     (cnt_o),
  .start_o   (start_o),
  .locked    (locked),
  .hw_set    (hw_set)
);

// File: tb/test_dma_req_latch.sv
module test_dma_req_latch;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       wdata = '0;
  logic             wr_cause = 1'b0, wr_mode = 1'b0, wr_cnt = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [N_SRC-1:0] preq = '0;
  logic [7:0]       cause_o, mode_o;
  logic [CNT_W-1:0] cnt_o;
  logic             start_o;

  int total = 0, bad = 0, n_start = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_latch #(.N_SRC(N_SRC), .CNT_W(CNT_W)) i_dma_req_latch (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .wr_cause_i(wr_cause),
    .wr_mode_i(wr_mode), .cnt_wdata_i(cnt_wdata), .wr_cnt_i(wr_cnt),
    .periph_req_i(preq), .cause_o(cause_o), .mode_o(mode_o),
    .cnt_o(cnt_o), .start_o(start_o)
  );

  always @(negedge clk) if (start_o) n_start++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_c(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_cause = 1'b1;
    @(negedge clk); wr_cause = 1'b0;
  endtask

  task automatic wr_m(input logic [7:0] v);
    @(negedge clk); wdata = v; wr_mode = 1'b1;
    @(negedge clk); wr_mode = 1'b0;
  endtask

  task automatic wr_n(input logic [CNT_W-1:0] v);
    @(negedge clk); cnt_wdata = v; wr_cnt = 1'b1;
    @(negedge clk); wr_cnt = 1'b0;
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk); preq[idx] = 1'b1;
    repeat (len) @(negedge clk);
    preq[idx] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cause_o == 8'h00, "R7 reset cause", cause_o, 0);
    chk(mode_o == 8'h00, "R7 reset mode", mode_o, 0);
    chk(cnt_o == '0, "R6 reset count", cnt_o, 0);
    chk(start_o == 1'b0, "R1 reset start", start_o, 0);
  endtask

  task automatic t_readback();
    wr_m(8'hFF);
    chk(mode_o == 8'h03, "R7 mode readback", mode_o, 3);
    wr_c(8'h5B);
    chk(cause_o == 8'h0B, "R7 cause readback", cause_o, 8'h0B);
    wr_m(8'h00);
    settle();
  endtask

  task automatic t_hw();
    int b;
    wr_c(8'h83);
    settle();
    wr_n(2);
    wr_m(8'h01);
    b = n_start;
    pulse(3, 5);
    chk(n_start - b == 1, "R3 long pulse one start", n_start - b, 1);
    chk(cnt_o == 1, "R3 count after start", cnt_o, 1);
    b = n_start;
    pulse(2, 2);
    chk(n_start - b == 0, "R3 unselected line", n_start - b, 0);
    chk(cnt_o == 1, "R3 count unchanged", cnt_o, 1);
  endtask

  task automatic t_drop();
    int b;
    wr_m(8'h00);
    b = n_start;
    pulse(3, 2);
    chk(n_start - b == 0, "R1 disabled no start", n_start - b, 0);
    chk(cause_o[7] == 1'b0, "R1 flag self-clear", cause_o[7], 0);
    wr_m(8'h01);
    repeat (10) @(negedge clk);
    chk(n_start - b == 0, "R1 no revival", n_start - b, 0);
    chk(cnt_o == 1, "R1 count kept", cnt_o, 1);
    wr_n(0);
    pulse(3, 2);
    chk(n_start - b == 0, "R1 zero count no start", n_start - b, 0);
    chk(cause_o[7] == 1'b0, "R1 flag clear at zero", cause_o[7], 0);
  endtask

  task automatic t_count();
    int b;
    wr_n(1);
    b = n_start;
    pulse(3, 2);
    chk(n_start - b == 1, "R6 last transfer", n_start - b, 1);
    chk(cnt_o == 0, "R6 reaches zero", cnt_o, 0);
    pulse(3, 2);
    chk(n_start - b == 1, "R6 idle at zero", n_start - b, 1);
    chk(cnt_o == 0, "R6 stays zero", cnt_o, 0);
  endtask

  task automatic t_sw();
    int b;
    wr_c(8'hA3);
    settle();
    wr_n(3);
    wr_c(8'hA3);
    chk(start_o == 1'b1, "R2 sw trigger start", start_o, 1);
    repeat (2) @(negedge clk);
    chk(cnt_o == 2, "R2 count after sw", cnt_o, 2);
    wr_c(8'h23);
    chk(start_o == 1'b0, "R2 bit5 alone", start_o, 0);
    repeat (3) @(negedge clk);
    chk(cnt_o == 2, "R2 count unchanged", cnt_o, 2);
    b = n_start;
    pulse(3, 3);
    chk(n_start - b == 0, "R4 lines masked in sw mode", n_start - b, 0);
    chk(cnt_o == 2, "R4 count unchanged", cnt_o, 2);
  endtask

  task automatic t_lock();
    int b;
    b = n_start;
    wr_c(8'h84);
    pulse(4, 2);
    chk(n_start - b == 0, "R5 dropped in lockout", n_start - b, 0);
    chk(cnt_o == 2, "R5 count kept", cnt_o, 2);
    settle();
    pulse(4, 2);
    chk(n_start - b == 1, "R5 granted after lockout", n_start - b, 1);
    chk(cnt_o == 1, "R5 count after", cnt_o, 1);
  endtask

  task automatic t_prio();
    wr_n(2);
    repeat (4) @(negedge clk);
    preq[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); wdata = 8'h04; wr_cause = 1'b1;
    @(negedge clk); wr_cause = 1'b0;
    chk(start_o == 1'b1, "R8 hw set beats host clear", start_o, 1);
    preq[4] = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_o == 1, "R8 count after", cnt_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_hw();
    t_drop();
    t_count();
    t_sw();
    t_lock();
    t_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule